// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block decides, once per cycle, whether the instruction held in the decode stage of an in-order, single-issue pipeline may leave for execution. The pipeline feeds five execution units of different depth: a one-cycle integer ALU, a load path, a pipelined floating-point adder, a pipelined multiplier and a divider that is not pipelined. Decode presents the unit class, up to two source registers and an optional destination register. The block answers with either an issue pulse or a stall, and gives the reason for any stall.

Instructions leave decode in program order, but they can finish out of order because the units differ in depth. The interlock therefore tracks four things. It counts down how long each unit stays occupied. It counts down, per register, the cycles until a pending result can be forwarded. It records, per register, how many cycles remain until the pending write-back. It also keeps a shift register of future cycles in which the single shared memory/write-back slot is already claimed. No arithmetic is performed here. The counters model when each result arrives.

Top module: `mcis_issue_check`

## Requirements
- R1: Directly after reset nothing is pending, and the first valid instruction issues in the same cycle it is presented, whatever its unit.
- R2: A consumer of an ALU result issues in the cycle right after its producer, with no stall.
- R3: A consumer of a load result presented right after the load stalls for exactly one cycle, with the raw cause bit set.
- R4: A consumer of an FP-add result waits exactly 3 cycles, and a consumer of a multiply result exactly 6, counted after the producer issues.
- R5: After a divide issues, a further divide is refused with the structural cause bit for the next 24 cycles and is accepted 25 cycles after the first.
- R6: The ALU, load, FP-add and multiply units each accept a new independent instruction in every cycle.
- R7: An instruction issued in cycle c writes back in cycle c+D, where D is 1 for ALU and load, 4 for FP add, 7 for multiply and 25 for divide. A candidate whose write-back cycle is already claimed stalls with the wb cause bit set.
- R8: A candidate whose destination matches that of an older in-flight instruction that would write back later than the candidate stalls with the waw cause bit set.
- R9: Writing a register that an older, still-executing instruction reads causes no stall.
- R10: A source whose enable is low, or a destination whose enable is low, takes no part in any hazard check.
- R11: stall_cause_o bit 0 is structural, bit 1 raw, bit 2 wb, and bit 3 waw. Several bits may be set at once. With id_valid_i low, issue_o, stall_o and all cause bits are 0. stall_o is high exactly when a valid instruction has a cause. A stalled instruction changes no tracked state.
- R12: Unit codes are 0 for ALU, 1 for load, 2 for FP add, 3 for multiply and 4 for divide. Codes 5 to 7 behave as ALU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Decode stage holds an instruction |
| id_unit_i | input | 3 | Unit class code |
| id_src1_i | input | RW | First source register |
| id_src1_en_i | input | 1 | First source is used |
| id_src2_i | input | RW | Second source register |
| id_src2_en_i | input | 1 | Second source is used |
| id_dst_i | input | RW | Destination register |
| id_dst_en_i | input | 1 | Destination is written |
| issue_o | output | 1 | Instruction leaves decode this cycle |
| stall_o | output | 1 | Instruction is held in decode |
| stall_cause_o | output | 4 | Stall reasons (structural, raw, wb, waw) |

## Verification
The first pattern is each producer unit followed at once by a dependent consumer. The stall count then shows that every unit's forwarding latency is modelled on its own. The second pattern is back-to-back independent work, which separates pipelined units from the blocking divider. Mixes of a long producer with short instructions make the shared write-back slot and the same-destination ordering collide, and the cause bits show which check fired. The remaining patterns are a write to a register that an older instruction still reads, disabled operand fields and out-of-range unit codes, and each of these must produce no stall. A behavioural model based on absolute cycle numbers is compared with all outputs on every cycle.

// File: rtl/mcis_pkg.sv
package mcis_pkg;

    localparam int NUNIT  = 5;
    localparam int UNIT_W = 3;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_ALU  = 3'd0,
        UNIT_LOAD = 3'd1,
        UNIT_FADD = 3'd2,
        UNIT_MUL  = 3'd3,
        UNIT_DIV  = 3'd4
    } unit_e;

    typedef int tab_t [NUNIT];

    // bit 0 busy, bit 1 raw, bit 2 wb slot, bit 3 waw
    typedef struct packed {
        logic waw;
        logic wbport;
        logic raw;
        logic busy;
    } cause_t;

    function automatic int clog2_min1(input int v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

    function automatic int tab_max(input tab_t t);
        int m;
        m = 0;
        for (int i = 0; i < NUNIT; i++)
            if (t[i] > m) m = t[i];
        return m;
    endfunction

    // codes beyond the last unit fall back to the ALU
    function automatic logic [UNIT_W-1:0] unit_index(input logic [UNIT_W-1:0] code);
        return (code > UNIT_W'(NUNIT - 1)) ? UNIT_W'(0) : code;
    endfunction

endpackage

// File: rtl/mcis_unit_occ.sv
module mcis_unit_occ
    import mcis_pkg::*;
#(
    parameter int II = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic ready_o
);

    localparam int W = clog2_min1(II);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (start_i)
            left_q <= W'(II - 1);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign ready_o = (left_q == '0);

    // R5: a blocking unit cannot take a second instruction on the next cycle
    p_refuse_reissue_r5: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !ready_o);

    // R5: the unit only becomes busy because something started
    p_busy_needs_start_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(start_i));

endmodule

// File: rtl/mcis_scoreboard.sv
module mcis_scoreboard #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int CW   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_i,
    input  logic [RW-1:0] src1_i,
    input  logic          src1_en_i,
    input  logic [RW-1:0] src2_i,
    input  logic          src2_en_i,
    input  logic [RW-1:0] dst_i,
    input  logic          dst_en_i,
    input  logic [CW-1:0] lat_i,
    input  logic [CW-1:0] exd_i,
    output logic          raw_o,
    output logic          waw_o
);

    // cycles until forwarding is possible
    logic [CW-1:0] rdy_q [NREG];
    // write-back distance bookkeeping: value v means slot v-1 from now
    logic [CW-1:0] wb_q  [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                rdy_q[r] <= '0;
                wb_q[r]  <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (issue_i && dst_en_i && (dst_i == RW'(r))) begin
                    rdy_q[r] <= lat_i;
                    wb_q[r]  <= exd_i - 1'b1;
                end else begin
                    if (rdy_q[r] != '0) rdy_q[r] <= rdy_q[r] - 1'b1;
                    if (wb_q[r]  != '0) wb_q[r]  <= wb_q[r]  - 1'b1;
                end
            end
        end
    end

    assign raw_o = (src1_en_i && (rdy_q[src1_i] != '0)) ||
                   (src2_en_i && (rdy_q[src2_i] != '0));

    // older writer finishing after the candidate blocks it
    assign waw_o = dst_en_i && (wb_q[dst_i] > exd_i);

    // R3: a producer with nonzero latency leaves its register pending
    p_raw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (issue_i && dst_en_i && (lat_i != '0)) |=> (rdy_q[$past(dst_i)] != '0));

    // R8: writes to one register never overtake each other
    p_waw_order_r8: assert property (@(posedge clk) disable iff (rst)
        (issue_i && dst_en_i) |-> (wb_q[dst_i] <= exd_i));

endmodule

// File: rtl/mcis_wb_ring.sv
module mcis_wb_ring #(
    parameter int SLOTS = 25,
    parameter int SW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_i,
    input  logic [SW-1:0] slot_i,
    output logic          taken_o
);

    logic [SLOTS-1:0] taken_q;
    logic [SLOTS-1:0] claim;

    assign claim   = issue_i ? (SLOTS'(1) << slot_i) : '0;
    assign taken_o = taken_q[slot_i];

    always_ff @(posedge clk) begin
        if (rst)
            taken_q <= '0;
        else
            taken_q <= (taken_q | claim) >> 1;
    end

    // R7: a claimed slot moves one step closer every cycle
    p_claim_advance_r7: assert property (@(posedge clk) disable iff (rst)
        (issue_i && (slot_i != '0)) |=> taken_q[$past(slot_i) - 1'b1]);

    // R7: no slot is ever claimed twice
    p_single_wb_r7: assert property (@(posedge clk) disable iff (rst)
        issue_i |-> !taken_q[slot_i]);

endmodule

// File: rtl/mcis_issue_check.sv
module mcis_issue_check
    import mcis_pkg::*;
#(
    parameter int   NREG  = 32,
    parameter tab_t LAT_T = '{0, 1, 3, 6, 24},
    parameter tab_t EXD_T = '{1, 1, 4, 7, 25},
    parameter tab_t II_T  = '{1, 1, 1, 1, 25},
    localparam int  RW    = clog2_min1(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid_i,
    input  logic [UNIT_W-1:0] id_unit_i,
    input  logic [RW-1:0]     id_src1_i,
    input  logic              id_src1_en_i,
    input  logic [RW-1:0]     id_src2_i,
    input  logic              id_src2_en_i,
    input  logic [RW-1:0]     id_dst_i,
    input  logic              id_dst_en_i,
    output logic              issue_o,
    output logic              stall_o,
    output logic [3:0]        stall_cause_o
);

    localparam int SLOTS  = tab_max(EXD_T);
    localparam int SW     = clog2_min1(SLOTS);
    localparam int LATMAX = tab_max(LAT_T);
    localparam int CW     = clog2_min1(((LATMAX > SLOTS) ? LATMAX : SLOTS) + 1);

    logic [UNIT_W-1:0] uidx;
    logic [NUNIT-1:0]  unit_ready;
    logic [CW-1:0]     lat_sel;
    logic [CW-1:0]     exd_sel;
    logic [SW-1:0]     slot_sel;
    logic              unit_ok;
    logic              raw_hit;
    logic              waw_hit;
    logic              slot_taken;
    cause_t            cause;

    assign uidx = unit_index(id_unit_i);

    always_comb begin
        lat_sel  = '0;
        exd_sel  = '0;
        slot_sel = '0;
        unit_ok  = 1'b0;
        for (int u = 0; u < NUNIT; u++) begin
            if (uidx == UNIT_W'(u)) begin
                lat_sel  = CW'(LAT_T[u]);
                exd_sel  = CW'(EXD_T[u]);
                slot_sel = SW'(EXD_T[u] - 1);
                unit_ok  = unit_ready[u];
            end
        end
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        if (II_T[u] > 1) begin : g_block
            mcis_unit_occ #(.II(II_T[u])) u_occ (
                .clk     (clk),
                .rst     (rst),
                .start_i (issue_o && (uidx == UNIT_W'(u))),
                .ready_o (unit_ready[u])
            );
        end else begin : g_pipe
            assign unit_ready[u] = 1'b1;
        end
    end

    mcis_scoreboard #(.NREG(NREG), .RW(RW), .CW(CW)) u_sb (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (issue_o),
        .src1_i    (id_src1_i),
        .src1_en_i (id_src1_en_i),
        .src2_i    (id_src2_i),
        .src2_en_i (id_src2_en_i),
        .dst_i     (id_dst_i),
        .dst_en_i  (id_dst_en_i),
        .lat_i     (lat_sel),
        .exd_i     (exd_sel),
        .raw_o     (raw_hit),
        .waw_o     (waw_hit)
    );

    mcis_wb_ring #(.SLOTS(SLOTS), .SW(SW)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .issue_i (issue_o),
        .slot_i  (slot_sel),
        .taken_o (slot_taken)
    );

    always_comb begin
        cause = '0;
        if (id_valid_i) begin
            cause.busy   = !unit_ok;
            cause.raw    = raw_hit;
            cause.wbport = slot_taken;
            cause.waw    = waw_hit;
        end
    end

    assign stall_o       = |cause;
    assign issue_o       = id_valid_i && !stall_o;
    assign stall_cause_o = cause;

endmodule

// File: tb/mcis_issue_check_tb.sv
`timescale 1ns/1ps
module mcis_issue_check_tb;
    import mcis_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       v;
    logic [2:0] unit;
    logic [4:0] s1, s2, d;
    logic       e1, e2, de;
    logic       issue_o, stall_o;
    logic [3:0] cause_o;

    always #4 clk = ~clk;

    mcis_issue_check u_dut (
        .clk(clk), .rst(rst), .id_valid_i(v), .id_unit_i(unit),
        .id_src1_i(s1), .id_src1_en_i(e1), .id_src2_i(s2), .id_src2_en_i(e2),
        .id_dst_i(d), .id_dst_en_i(de),
        .issue_o(issue_o), .stall_o(stall_o), .stall_cause_o(cause_o)
    );

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    // reference model in absolute cycle numbers
    int  lat_m [5] = '{0, 1, 3, 6, 24};
    int  dep_m [5] = '{1, 1, 4, 7, 25};
    int  ii_m  [5] = '{1, 1, 1, 1, 25};
    int  fwd_at [32];
    int  wb_at  [32];
    int  free_at [5];
    bit  claimed [int];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit vi, input int ui, input int a1, input bit ea1,
                        input int a2, input bit ea2, input int dd, input bit ed,
                        input string tag, output bit issued, output int cz);
        int c, u, wbc, ecause, eiss, got, want;
        bit b_busy, b_raw, b_wb, b_waw;
        @(negedge clk);
        v = vi; unit = 3'(ui); s1 = 5'(a1); e1 = ea1; s2 = 5'(a2); e2 = ea2;
        d = 5'(dd); de = ed;
        #1;
        c = cyc;
        u = (ui > 4) ? 0 : ui;
        wbc = c + dep_m[u];
        b_busy = c < free_at[u];
        b_raw  = (ea1 && c < fwd_at[a1]) || (ea2 && c < fwd_at[a2]);
        b_wb   = claimed.exists(wbc);
        b_waw  = ed && (wb_at[dd] > wbc);
        ecause = vi ? {b_waw, b_wb, b_raw, b_busy} : 0;
        eiss   = (vi && ecause == 0) ? 1 : 0;
        got  = {issue_o, stall_o, cause_o};
        want = (eiss << 5) | ((vi && ecause != 0) ? 16 : 0) | ecause;
        chk(got == want, tag, "issue/stall/cause", got, want);
        if (eiss != 0) begin
            if (ed) begin
                fwd_at[dd] = c + lat_m[u] + 1;
                wb_at[dd]  = wbc;
            end
            free_at[u] = c + ii_m[u];
            claimed[wbc] = 1'b1;
        end
        issued = (eiss != 0);
        cz = ecause;
    endtask

    task automatic idle(input int n);
        bit i; int cz;
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R11", i, cz);
    endtask

    task automatic push(input int ui, input int a1, input bit ea1, input int a2,
                        input bit ea2, input int dd, input bit ed, input string tag,
                        output int stalls, output int first_cause);
        bit i; int cz;
        stalls = 0; first_cause = 0;
        for (int k = 0; k < 60; k++) begin
            step(1, ui, a1, ea1, a2, ea2, dd, ed, tag, i, cz);
            if (i) break;
            if (stalls == 0) first_cause = cz;
            stalls++;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int n, fc;
        for (int r = 0; r < 32; r++) begin fwd_at[r] = 0; wb_at[r] = 0; end
        for (int u = 0; u < 5; u++) free_at[u] = 0;
        rst = 1'b1; v = 0; unit = 0; s1 = 0; s2 = 0; d = 0; e1 = 0; e2 = 0; de = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        idle(2);                                                    // R11 idle outputs zero
        push(UNIT_MUL, 0, 0, 0, 0, 1, 1, "R1", n, fc);
        chk(n == 0, "R1", "stalls after reset", n, 0);
        idle(30);

        push(UNIT_ALU, 0, 0, 0, 0, 2, 1, "R2", n, fc);
        push(UNIT_ALU, 2, 1, 0, 0, 3, 1, "R2", n, fc);
        chk(n == 0, "R2", "alu-use stalls", n, 0);
        idle(10);

        push(UNIT_LOAD, 0, 0, 0, 0, 4, 1, "R3", n, fc);
        push(UNIT_ALU, 0, 0, 4, 1, 5, 1, "R3", n, fc);
        chk(n == 1, "R3", "load-use stalls", n, 1);
        chk(fc == 2, "R3", "load-use cause", fc, 2);
        idle(10);

        push(UNIT_FADD, 0, 0, 0, 0, 6, 1, "R4", n, fc);
        push(UNIT_ALU, 6, 1, 0, 0, 7, 1, "R4", n, fc);
        chk(n == 3, "R4", "fadd-use stalls", n, 3);
        idle(10);
        push(UNIT_MUL, 0, 0, 0, 0, 8, 1, "R4", n, fc);
        push(UNIT_FADD, 8, 1, 0, 0, 9, 1, "R4", n, fc);
        chk(n == 6, "R4", "mul-use stalls", n, 6);
        idle(10);

        push(UNIT_DIV, 0, 0, 0, 0, 10, 1, "R5", n, fc);
        push(UNIT_DIV, 0, 0, 0, 0, 11, 1, "R5", n, fc);
        chk(n == 24, "R5", "div-div stalls", n, 24);
        chk(fc == 1, "R5", "div-div cause", fc, 1);
        idle(30);
        push(UNIT_DIV, 0, 0, 0, 0, 12, 1, "R11", n, fc);
        push(UNIT_DIV, 12, 1, 0, 0, 13, 1, "R11", n, fc);
        chk(fc == 3, "R11", "combined cause", fc, 3);
        chk(n == 24, "R11", "combined stalls", n, 24);
        idle(30);

        push(UNIT_FADD, 0, 0, 0, 0, 14, 1, "R6", n, fc);
        push(UNIT_FADD, 0, 0, 0, 0, 15, 1, "R6", n, fc);
        chk(n == 0, "R6", "fadd back-to-back", n, 0);
        push(UNIT_MUL, 0, 0, 0, 0, 16, 1, "R6", n, fc);
        push(UNIT_MUL, 0, 0, 0, 0, 17, 1, "R6", n, fc);
        chk(n == 0, "R6", "mul back-to-back", n, 0);
        push(UNIT_LOAD, 0, 0, 0, 0, 18, 1, "R6", n, fc);
        push(UNIT_LOAD, 0, 0, 0, 0, 19, 1, "R6", n, fc);
        chk(n == 0, "R6", "load back-to-back", n, 0);
        idle(12);

        push(UNIT_FADD, 0, 0, 0, 0, 20, 1, "R7", n, fc);
        push(UNIT_ALU, 0, 0, 0, 0, 21, 1, "R7", n, fc);
        push(UNIT_ALU, 0, 0, 0, 0, 22, 1, "R7", n, fc);
        push(UNIT_ALU, 0, 0, 0, 0, 23, 1, "R7", n, fc);
        chk(n == 1, "R7", "wb slot stalls", n, 1);
        chk(fc == 4, "R7", "wb slot cause", fc, 4);
        idle(12);

        push(UNIT_MUL, 0, 0, 0, 0, 24, 1, "R8", n, fc);
        push(UNIT_ALU, 0, 0, 0, 0, 24, 1, "R8", n, fc);
        chk(n == 6, "R8", "waw stalls", n, 6);
        chk(fc == 8, "R8", "waw cause", fc, 8);
        idle(30);

        push(UNIT_DIV, 25, 1, 26, 1, 27, 1, "R9", n, fc);
        push(UNIT_ALU, 0, 0, 0, 0, 25, 1, "R9", n, fc);
        chk(n == 0, "R9", "war stalls", n, 0);
        idle(30);

        push(UNIT_LOAD, 0, 0, 0, 0, 28, 1, "R10", n, fc);
        push(UNIT_ALU, 28, 0, 28, 0, 29, 1, "R10", n, fc);
        chk(n == 0, "R10", "disabled sources", n, 0);
        push(UNIT_MUL, 0, 0, 0, 0, 30, 0, "R10", n, fc);
        push(UNIT_LOAD, 30, 1, 0, 0, 31, 1, "R10", n, fc);
        chk(n == 0, "R10", "disabled dest", n, 0);
        idle(12);

        push(7, 0, 0, 0, 0, 3, 1, "R12", n, fc);
        push(UNIT_ALU, 3, 1, 0, 0, 4, 1, "R12", n, fc);
        chk(n == 0, "R12", "code 7 as alu", n, 0);
        push(UNIT_FADD, 0, 0, 0, 0, 5, 1, "R12", n, fc);
        push(UNIT_ALU, 5, 1, 0, 0, 6, 1, "R12", n, fc);
        chk(n == 3, "R12", "code 2 as fadd", n, 3);
        idle(5);

        summary();
        $finish;
    end

endmodule